// File: doc/BRIEF.md
# Paged Segment Address Translator

This block turns a virtual address, given as a segment number and an offset inside that segment, into a physical address. It first fetches the segment descriptor, which holds a limit and a base. An offset above the limit ends the translation with a limit error. Otherwise the offset is added to the base to give a linear address. The linear address is then translated by a two-level page-table walk: a top-level entry picks one of several second-level tables, and the second-level entry supplies the real page number. That real page number is joined to the low linear bits to form the physical address. If the entry read at either level is marked invalid, the translation ends with a page fault instead.

The segment table and both page-table levels are small internal arrays. They are loaded through a single write-only configuration port. A translation starts with a one-cycle request while the block is idle. The block stays busy while it walks the tables, then raises a one-cycle done pulse together with the result.

Top module: `seg_page_xlate`

## Requirements
- R1: After reset, busy, done, limitErr and pageFault are 0 and paddr is 0.
- R2: A request is accepted only while busy is 0, and busy is 1 from the next cycle. done is a single-cycle pulse during which busy is 0. A full translation raises done 4 cycles after the accepting edge, a limit error after 2 cycles, and a top-level fault after 3 cycles.
- R3: reqValid, reqSeg and reqOff are ignored while busy is 1. The result always belongs to the accepted request.
- R4: If offset > limit, the result is limitErr=1 with pageFault=0 and paddr=0. An offset equal to the limit passes the check.
- R5: The linear address is (base + offset) mod 2^16. Bits [15:12] index the top table, bits [11:8] index the selected second-level table, and bits [7:0] are the page offset.
- R6: If the top-level entry is invalid, the result is pageFault=1 with limitErr=0 and paddr=0.
- R7: If the second-level entry is invalid, the result is pageFault=1 with limitErr=0 and paddr=0, raised 4 cycles after the accepting edge.
- R8: On success, paddr = {real page number, linear[7:0]}, and limitErr and pageFault are both 0.
- R9: The configuration port writes when cfgWe=1, and cfgSel chooses the table:
  - cfgSel=0 writes segment cfgAddr[2:0], with limit=cfgData[27:16] and base=cfgData[15:0].
  - cfgSel=1 writes top entry cfgAddr[3:0], with valid=cfgData[2] and table=cfgData[1:0].
  - cfgSel=2 writes second-level entry cfgAddr[5:0]={table, index}, with valid=cfgData[8] and rpn=cfgData[7:0].
  - After reset, every entry is invalid or zero.
- R10: paddr, limitErr and pageFault keep their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request |
| reqSeg | input | 3 | Segment number |
| reqOff | input | 12 | Offset within the segment |
| busy | output | 1 | Translation in progress |
| done | output | 1 | One-cycle completion pulse |
| paddr | output | 16 | Physical address |
| limitErr | output | 1 | Offset exceeded the segment limit |
| pageFault | output | 1 | Invalid page-table entry met |
| cfgWe | input | 1 | Table write strobe |
| cfgSel | input | 2 | Table select |
| cfgAddr | input | 6 | Entry index |
| cfgData | input | 28 | Entry contents |

## Verification
Two things can happen in the same cycle: a new request arriving, and a translation that is still walking its tables. The bench provokes this by holding reqValid high with a different segment and offset in every cycle of a walk. It drops that request only in the cycle where done appears. The result is judged correct only if it matches the first request and arrives with that request's own latency, so a request taken in mid-walk shows up as a wrong address, a wrong flag or a shifted done pulse.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEG,
    ST_CHK,
    ST_L1,
    ST_L2
  } walkState_t;

  typedef struct packed {
    logic accept;
    logic readSeg;
    logic checkLim;
    logic walkL1;
    logic walkL2;
  } walkStrb_t;
endpackage

// File: rtl/pst_ctrl.sv
module pst_ctrl
  import pst_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      overLimit,
  input  logic      l1Miss,
  output walkStrb_t strb,
  output logic      busy
);
  walkState_t st, nxt;

  always_comb begin
    nxt  = st;
    strb = '0;
    unique case (st)
      ST_IDLE: if (reqValid) begin
        strb.accept = 1'b1;
        nxt = ST_SEG;
      end
      ST_SEG: begin
        strb.readSeg = 1'b1;
        nxt = ST_CHK;
      end
      ST_CHK: begin
        strb.checkLim = 1'b1;
        nxt = overLimit ? ST_IDLE : ST_L1;
      end
      ST_L1: begin
        strb.walkL1 = 1'b1;
        nxt = l1Miss ? ST_IDLE : ST_L2;
      end
      ST_L2: begin
        strb.walkL2 = 1'b1;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else st <= nxt;
  end

  assign busy = (st != ST_IDLE);

  // R6: the second level is only read right after a passing first-level read
  p_walk_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.walkL2 |-> $past(strb.walkL1) && !$past(l1Miss));
  // R2: the limit check is always preceded by the descriptor read
  p_seg_before_chk_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.checkLim |-> $past(strb.readSeg));
endmodule

// File: rtl/pst_datapath.sv
module pst_datapath
  import pst_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int LIN_W = 16,
  parameter int L1_W  = 4,
  parameter int L2_W  = 4,
  parameter int TBL_W = 2,
  parameter int RPN_W = 8,
  parameter int CFG_AW = TBL_W + L2_W,
  parameter int CFG_DW = OFF_W + LIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrb_t         strb,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_DW-1:0] cfgData,
  output logic              overLimit,
  output logic              l1Miss,
  output logic              done,
  output logic [RPN_W+LIN_W-L1_W-L2_W-1:0] paddr,
  output logic              limitErr,
  output logic              pageFault
);
  localparam int PO_W  = LIN_W - L1_W - L2_W;
  localparam int PA_W  = RPN_W + PO_W;
  localparam int SEG_N = 1 << SEG_W;
  localparam int L1_N  = 1 << L1_W;
  localparam int L2_N  = 1 << (TBL_W + L2_W);

  logic [OFF_W-1:0] segLimit [SEG_N];
  logic [LIN_W-1:0] segBase  [SEG_N];
  logic             l1Valid  [L1_N];
  logic [TBL_W-1:0] l1Tbl    [L1_N];
  logic             l2Valid  [L2_N];
  logic [RPN_W-1:0] l2Rpn    [L2_N];

  logic [SEG_W-1:0] segReg;
  logic [OFF_W-1:0] offReg, limitReg;
  logic [LIN_W-1:0] baseReg, linReg;
  logic [TBL_W-1:0] tblReg;

  logic [L1_W-1:0]       l1Idx;
  logic [TBL_W+L2_W-1:0] l2Idx;

  assign l1Idx     = linReg[LIN_W-1 -: L1_W];
  assign l2Idx     = {tblReg, linReg[PO_W +: L2_W]};
  assign overLimit = offReg > limitReg;
  assign l1Miss    = !l1Valid[l1Idx];

  // table loading
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SEG_N; i++) begin
        segLimit[i] <= '0;
        segBase[i]  <= '0;
      end
      for (int i = 0; i < L1_N; i++) begin
        l1Valid[i] <= 1'b0;
        l1Tbl[i]   <= '0;
      end
      for (int i = 0; i < L2_N; i++) begin
        l2Valid[i] <= 1'b0;
        l2Rpn[i]   <= '0;
      end
    end else if (cfgWe) begin
      unique case (cfgSel)
        2'd0: begin
          segLimit[cfgAddr[SEG_W-1:0]] <= cfgData[LIN_W +: OFF_W];
          segBase[cfgAddr[SEG_W-1:0]]  <= cfgData[LIN_W-1:0];
        end
        2'd1: begin
          l1Valid[cfgAddr[L1_W-1:0]] <= cfgData[TBL_W];
          l1Tbl[cfgAddr[L1_W-1:0]]   <= cfgData[TBL_W-1:0];
        end
        2'd2: begin
          l2Valid[cfgAddr] <= cfgData[RPN_W];
          l2Rpn[cfgAddr]   <= cfgData[RPN_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // translation datapath
  always_ff @(posedge clk) begin
    if (!rstN) begin
      segReg    <= '0;
      offReg    <= '0;
      limitReg  <= '0;
      baseReg   <= '0;
      linReg    <= '0;
      tblReg    <= '0;
      done      <= 1'b0;
      paddr     <= '0;
      limitErr  <= 1'b0;
      pageFault <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strb.accept) begin
        segReg <= reqSeg;
        offReg <= reqOff;
      end
      if (strb.readSeg) begin
        limitReg <= segLimit[segReg];
        baseReg  <= segBase[segReg];
      end
      if (strb.checkLim) begin
        if (overLimit) begin
          done      <= 1'b1;
          limitErr  <= 1'b1;
          pageFault <= 1'b0;
          paddr     <= '0;
        end else begin
          linReg <= baseReg + LIN_W'(offReg);
        end
      end
      if (strb.walkL1) begin
        if (l1Miss) begin
          done      <= 1'b1;
          limitErr  <= 1'b0;
          pageFault <= 1'b1;
          paddr     <= '0;
        end else begin
          tblReg <= l1Tbl[l1Idx];
        end
      end
      if (strb.walkL2) begin
        done      <= 1'b1;
        limitErr  <= 1'b0;
        pageFault <= !l2Valid[l2Idx];
        paddr     <= l2Valid[l2Idx] ? {l2Rpn[l2Idx], linReg[PO_W-1:0]} : PA_W'(0);
      end
    end
  end

  // R2: done never lasts two cycles
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R3: latched request fields only change on acceptance
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accept |=> $stable(offReg) && $stable(segReg));
  // R4: a limit error is only reported for an offset above the limit
  p_limit_r4: assert property (@(posedge clk) disable iff (!rstN)
    done && limitErr |-> $past(offReg > limitReg) && !pageFault);
  // R10: results hold between completions
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(paddr) && $stable(limitErr) && $stable(pageFault));
  // R8: an error result never carries an address
  p_err_no_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    done && (limitErr || pageFault) |-> paddr == '0);
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import pst_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int LIN_W = 16,
  parameter int L1_W  = 4,
  parameter int L2_W  = 4,
  parameter int TBL_W = 2,
  parameter int RPN_W = 8,
  parameter int PA_W  = RPN_W + LIN_W - L1_W - L2_W,
  parameter int CFG_AW = TBL_W + L2_W,
  parameter int CFG_DW = OFF_W + LIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [OFF_W-1:0]  reqOff,
  output logic              busy,
  output logic              done,
  output logic [PA_W-1:0]   paddr,
  output logic              limitErr,
  output logic              pageFault,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_DW-1:0] cfgData
);
  walkStrb_t strb;
  logic      overLimit, l1Miss;

  pst_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .overLimit(overLimit), .l1Miss(l1Miss),
    .strb(strb), .busy(busy)
  );

  pst_datapath #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .LIN_W(LIN_W), .L1_W(L1_W),
    .L2_W(L2_W), .TBL_W(TBL_W), .RPN_W(RPN_W),
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqSeg(reqSeg), .reqOff(reqOff),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .overLimit(overLimit), .l1Miss(l1Miss),
    .done(done), .paddr(paddr), .limitErr(limitErr), .pageFault(pageFault)
  );

  // R2: completion is reported only once the walk has left its busy states
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R6: both error flags are never raised together
  p_one_error_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(limitErr && pageFault));
endmodule

// File: tb/test_seg_page_xlate.sv
`timescale 1ns/1ps
module test_seg_page_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqSeg = '0;
  logic [11:0] reqOff = '0;
  logic        busy, done, limitErr, pageFault;
  logic [15:0] paddr;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [5:0]  cfgAddr = '0;
  logic [27:0] cfgData = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [11:0] mLim  [8];
  logic [15:0] mBase [8];
  logic        mL1V  [16];
  logic [1:0]  mL1T  [16];
  logic        mL2V  [64];
  logic [7:0]  mL2R  [64];

  always #2.5 clk = ~clk;

  seg_page_xlate i_seg_page_xlate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSeg(reqSeg), .reqOff(reqOff),
    .busy(busy), .done(done), .paddr(paddr), .limitErr(limitErr), .pageFault(pageFault),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgAddr(cfgAddr), .cfgData(cfgData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [5:0] addr, input logic [27:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgAddr = addr; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
    case (sel)
      2'd0: begin mLim[addr[2:0]] = data[27:16]; mBase[addr[2:0]] = data[15:0]; end
      2'd1: begin mL1V[addr[3:0]] = data[2]; mL1T[addr[3:0]] = data[1:0]; end
      default: begin mL2V[addr] = data[8]; mL2R[addr] = data[7:0]; end
    endcase
  endtask

  // kind: 0 success, 1 limit error, 2 top-level fault, 3 second-level fault
  function automatic int refKind(input logic [2:0] s, input logic [11:0] o);
    logic [15:0] lin;
    logic [5:0]  j;
    if (o > mLim[s]) return 1;
    lin = mBase[s] + {4'd0, o};
    if (!mL1V[lin[15:12]]) return 2;
    j = {mL1T[lin[15:12]], lin[11:8]};
    if (!mL2V[j]) return 3;
    return 0;
  endfunction

  function automatic logic [15:0] refAddr(input logic [2:0] s, input logic [11:0] o);
    logic [15:0] lin;
    if (refKind(s, o) != 0) return 16'h0;
    lin = mBase[s] + {4'd0, o};
    return {mL2R[{mL1T[lin[15:12]], lin[11:8]}], lin[7:0]};
  endfunction

  task automatic translate(input logic [2:0] s, input logic [11:0] o, input bit junk);
    int kind, expLat, lat;
    logic [15:0] expPa;
    kind   = refKind(s, o);
    expPa  = refAddr(s, o);
    expLat = (kind == 1) ? 2 : (kind == 2) ? 3 : 4;
    lat = 0;
    @(negedge clk);
    reqValid = 1'b1; reqSeg = s; reqOff = o;
    @(negedge clk);
    reqValid = junk; reqSeg = ~s; reqOff = ~o;
    check(busy == 1'b1, "R2 busy after accept", busy, 1);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (done) begin
        lat = k;
        reqValid = 1'b0;
        break;
      end
      reqValid = junk;
    end
    reqValid = 1'b0;
    check(lat == expLat, junk ? "R3 latency with request held" : "R2 latency", lat, expLat);
    check(limitErr == (kind == 1), "R4 limitErr", limitErr, kind == 1);
    check(pageFault == (kind >= 2), kind == 3 ? "R7 pageFault" : "R6 pageFault", pageFault, kind >= 2);
    check(paddr == expPa, junk ? "R3 R8 paddr" : "R8 R5 paddr", paddr, expPa);
    check(busy == 1'b0, "R2 idle at done", busy, 0);
    @(negedge clk);
    check(!done && paddr == expPa, "R10 result held", paddr, expPa);
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mLim[i] = 0; mBase[i] = 0; end
    for (int i = 0; i < 16; i++) begin mL1V[i] = 0; mL1T[i] = 0; end
    for (int i = 0; i < 64; i++) begin mL2V[i] = 0; mL2R[i] = 0; end
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(!busy && !done && !limitErr && !pageFault && paddr == 0, "R1 reset state", paddr, 0);
    rstN = 1'b1;
    // R9: reset contents give limit 0 and an invalid top entry
    translate(3'd0, 12'd0, 0);
    translate(3'd0, 12'd1, 0);
    // directed: limit boundary, wrap-around, both fault levels
    cfgWrite(2'd0, 6'd7, {12'h020, 16'hFFF0});
    cfgWrite(2'd1, 6'd0, 28'h6);      // top 0 -> table 2, valid
    cfgWrite(2'd2, 6'h20, 28'h1AB);   // table 2 index 0 -> rpn AB, valid
    translate(3'd7, 12'h020, 0);      // R4 equal passes, R5 wrap to 0x0010
    translate(3'd7, 12'h021, 0);      // R4 above limit
    translate(3'd7, 12'h00F, 0);      // lin FFFF: top 15 invalid, R6
    cfgWrite(2'd1, 6'd15, 28'h5);     // top 15 -> table 1
    translate(3'd7, 12'h00F, 0);      // table 1 index 15 invalid, R7
    translate(3'd7, 12'h018, 1);      // R3 request held during walk
    // random tables
    for (int i = 0; i < 8; i++) cfgWrite(2'd0, 6'(i), {12'($urandom), 16'($urandom)});
    for (int i = 0; i < 16; i++) cfgWrite(2'd1, 6'(i), {25'd0, 1'(($urandom % 8) != 0), 2'($urandom)});
    for (int i = 0; i < 64; i++) cfgWrite(2'd2, 6'(i), {19'd0, 1'(($urandom % 8) != 0), 8'($urandom)});
    for (int n = 0; n < 400; n++) begin
      logic [2:0]  s;
      logic [11:0] o;
      s = 3'($urandom);
      o = (($urandom % 4) == 0) ? 12'($urandom) : 12'($urandom % (32'(mLim[s]) + 1));
      translate(s, o, 1'(($urandom % 3) == 0));
    end
    summary();
  end
endmodule